// File: doc/BRIEF.md
# I2C Variable-Width Register Slave

This block is an I2C target that serves a register map in which every subaddress has its own width of one to four bytes. A bus controller writes a subaddress byte after the device address and then streams data bytes. Each register is committed to the attached register file only once all of its bytes have arrived. After a register completes, the pointer moves to the next subaddress, and the width of that subaddress sets how many bytes the next register takes.

A read is a write of the subaddress followed by a repeated START and the device address with the read bit set. The block then returns bytes for as long as the controller acknowledges them, moving through registers in the same way. SCL and SDA are sampled in the system clock domain, synchronised and deglitched. The block only ever pulls SDA low and never holds SCL. The register storage sits outside the block, behind a parallel write strobe and a combinational read port.

Top module: `i2cvw_slave`

## Requirements
- R1: While reset is held and in the first cycle after it, `sda_oe` is 0 and `reg_wr_en` is 0.
- R2: A device address byte whose upper 7 bits equal `DEV_ADDR` is acknowledged (SDA pulled low in the ninth clock). Any other address gets no acknowledge. The block then acknowledges no byte and writes no register until the next START.
- R3: A subaddress `a` below `NUM_REGS` is `(a mod 4) + 1` bytes wide. Its data arrives most significant byte first. When its last byte arrives, `reg_wr_en` pulses for one cycle with `reg_wr_addr = a` and `reg_wr_data` right-aligned, with every unused upper bit 0.
- R4: If a STOP or START arrives before a register has received all its bytes, that register is not written.
- R5: During a write, after each completed register the subaddress increments by one. The stream continues into the next register using that register's width.
- R6: After the subaddress is written and a repeated START is issued with the read bit set to 1, each byte is taken from the low bytes of `reg_rd_data` at `reg_rd_addr`, most significant byte first. Bytes keep coming, with the pointer advancing across registers as in R5, for as long as the controller acknowledges.
- R7: When the controller answers a read byte with no acknowledge, the block releases SDA (`sda_oe` = 0) and drives nothing until the next START. The block changes `sda_oe` only while SCL is low.
- R8: A subaddress at or above `NUM_REGS` counts as one byte. It reads as 0x00 whatever `reg_rd_data` holds. A byte written to it is acknowledged, but `reg_wr_en` never pulses for it.
- R9: A low pulse on SCL shorter than `FILT_LEN` system clocks during its high phase does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| reg_rd_addr | output | 8 | Subaddress currently addressed for reading |
| reg_rd_data | input | 32 | Combinational read data of `reg_rd_addr` |
| reg_wr_en | output | 1 | One-cycle commit strobe of a complete register |
| reg_wr_addr | output | 8 | Subaddress being committed |
| reg_wr_data | output | 32 | Right-aligned register value being committed |

## Verification
The assertions assume that the controller holds SCL low for well over the filter and synchroniser delay. That way every change of `sda_oe` lands inside an SCL low phase. They also assume that SDA only changes while SCL is high when a START or STOP is intended. The bench's bus tasks keep a fixed quarter-bit of ten system clocks and move SDA only in the middle of a low phase, except inside the START and STOP tasks. The one SCL disturbance the bench injects is a two-cycle glitch, which stays below the filter length.

// File: rtl/i2cvw_pkg.sv
`timescale 1ns/1ps
package i2cvw_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_SUB,
      ST_SUB_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_RD_LOAD,
      ST_SKIP
   } i2cvw_state_t;

   // subaddress lies inside the implemented map
   function automatic logic reg_defined(input logic [7:0] a, input int unsigned nregs);
      return ({24'd0, a} < nregs);
   endfunction

   // index of the last byte of a subaddress (width minus one)
   function automatic logic [1:0] reg_last(input logic [7:0] a, input int unsigned nregs);
      return reg_defined(a, nregs) ? a[1:0] : 2'd0;
   endfunction

endpackage

// File: rtl/i2cvw_deglitch.sv
`timescale 1ns/1ps
module i2cvw_deglitch #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end

   generate
      if (FILT_LEN == 1) begin : g_bypass
         assign dout = sync_q[SYNC_STAGES-1];
      end else begin : g_window
         logic [FILT_LEN-1:0] win_q;
         logic                out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_q <= '1;
               out_q <= 1'b1;
            end else begin
               win_q <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
               if (&win_q)       out_q <= 1'b1;
               else if (~|win_q) out_q <= 1'b0;
            end
         end
         assign dout = out_q;
      end
   endgenerate
endmodule

// File: rtl/i2cvw_busev.sv
`timescale 1ns/1ps
module i2cvw_busev (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic ev_start,
   output logic ev_stop,
   output logic ev_rise,
   output logic ev_fall
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign ev_start = scl_f & scl_q &  sda_q & ~sda_f;
   assign ev_stop  = scl_f & scl_q & ~sda_q &  sda_f;
   assign ev_rise  = scl_f & ~scl_q;
   assign ev_fall  = ~scl_f & scl_q;
endmodule

// File: rtl/i2cvw_engine.sv
`timescale 1ns/1ps
module i2cvw_engine
   import i2cvw_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR = 7'h2A,
   parameter int unsigned NUM_REGS = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ev_start,
   input  logic        ev_stop,
   input  logic        ev_rise,
   input  logic        ev_fall,
   input  logic        sda_f,
   output logic        sda_oe,
   output logic [7:0]  rd_addr,
   input  logic [31:0] rd_data,
   output logic        wr_en,
   output logic [7:0]  wr_addr,
   output logic [31:0] wr_data
);
   i2cvw_state_t st_q;
   logic [3:0]   bit_q;
   logic [7:0]   shf_q, ptr_q, tx_q, waddr_q;
   logic [1:0]   idx_q;
   logic [23:0]  acc_q;
   logic [31:0]  wdata_q;
   logic         rw_q, oe_q, wen_q;

   logic         cur_def, last_byte;
   logic [1:0]   cur_last, sh;
   logic [7:0]   rd_byte;

   always_comb begin
      cur_def   = reg_defined(ptr_q, NUM_REGS);
      cur_last  = reg_last(ptr_q, NUM_REGS);
      last_byte = (idx_q == cur_last);
      sh        = cur_last - idx_q;
      case (sh)
         2'd0:    rd_byte = rd_data[7:0];
         2'd1:    rd_byte = rd_data[15:8];
         2'd2:    rd_byte = rd_data[23:16];
         default: rd_byte = rd_data[31:24];
      endcase
      if (!cur_def) rd_byte = 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         bit_q   <= '0;
         shf_q   <= '0;
         ptr_q   <= '0;
         tx_q    <= '0;
         idx_q   <= '0;
         acc_q   <= '0;
         rw_q    <= 1'b0;
         oe_q    <= 1'b0;
         wen_q   <= 1'b0;
         waddr_q <= '0;
         wdata_q <= '0;
      end else begin
         wen_q <= 1'b0;
         if (ev_start) begin
            st_q  <= ST_DEV;
            bit_q <= '0;
            oe_q  <= 1'b0;
            idx_q <= '0;
            acc_q <= '0;
         end else if (ev_stop) begin
            st_q  <= ST_IDLE;
            oe_q  <= 1'b0;
            idx_q <= '0;
            acc_q <= '0;
         end else begin
            case (st_q)
               ST_DEV, ST_SUB, ST_WR: begin
                  if (ev_rise) begin
                     shf_q <= {shf_q[6:0], sda_f};
                     bit_q <= bit_q + 4'd1;
                  end else if (ev_fall && bit_q == 4'd8) begin
                     bit_q <= '0;
                     if (st_q == ST_DEV) begin
                        if (shf_q[7:1] == DEV_ADDR) begin
                           oe_q <= 1'b1;
                           rw_q <= shf_q[0];
                           st_q <= ST_DEV_ACK;
                        end else begin
                           st_q <= ST_SKIP;
                        end
                     end else if (st_q == ST_SUB) begin
                        oe_q  <= 1'b1;
                        ptr_q <= shf_q;
                        idx_q <= '0;
                        acc_q <= '0;
                        st_q  <= ST_SUB_ACK;
                     end else begin
                        oe_q <= 1'b1;
                        st_q <= ST_WR_ACK;
                        if (last_byte) begin
                           wen_q   <= cur_def;
                           waddr_q <= ptr_q;
                           wdata_q <= {acc_q, shf_q};
                           ptr_q   <= ptr_q + 8'd1;
                           idx_q   <= '0;
                           acc_q   <= '0;
                        end else begin
                           acc_q <= {acc_q[15:0], shf_q};
                           idx_q <= idx_q + 2'd1;
                        end
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (ev_fall) begin
                     bit_q <= '0;
                     if (rw_q) begin
                        oe_q <= ~rd_byte[7];
                        tx_q <= {rd_byte[6:0], 1'b0};
                        st_q <= ST_RD;
                     end else begin
                        oe_q <= 1'b0;
                        st_q <= ST_SUB;
                     end
                  end
               end
               ST_SUB_ACK, ST_WR_ACK: begin
                  if (ev_fall) begin
                     oe_q <= 1'b0;
                     st_q <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (ev_rise) begin
                     bit_q <= bit_q + 4'd1;
                  end else if (ev_fall) begin
                     if (bit_q == 4'd8) begin
                        oe_q  <= 1'b0;
                        bit_q <= '0;
                        st_q  <= ST_RD_ACK;
                     end else begin
                        oe_q <= ~tx_q[7];
                        tx_q <= {tx_q[6:0], 1'b0};
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (ev_rise) begin
                     if (sda_f) begin
                        st_q <= ST_SKIP;
                     end else begin
                        st_q <= ST_RD_LOAD;
                        if (last_byte) begin
                           ptr_q <= ptr_q + 8'd1;
                           idx_q <= '0;
                        end else begin
                           idx_q <= idx_q + 2'd1;
                        end
                     end
                  end
               end
               ST_RD_LOAD: begin
                  if (ev_fall) begin
                     oe_q  <= ~rd_byte[7];
                     tx_q  <= {rd_byte[6:0], 1'b0};
                     bit_q <= '0;
                     st_q  <= ST_RD;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe  = oe_q;
   assign rd_addr = ptr_q;
   assign wr_en   = wen_q;
   assign wr_addr = waddr_q;
   assign wr_data = wdata_q;
endmodule

// File: rtl/i2cvw_slave.sv
`timescale 1ns/1ps
module i2cvw_slave #(
   parameter logic [6:0]  DEV_ADDR    = 7'h2A,
   parameter int unsigned NUM_REGS    = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_i,
   input  logic        sda_i,
   output logic        sda_oe,
   output logic [7:0]  reg_rd_addr,
   input  logic [31:0] reg_rd_data,
   output logic        reg_wr_en,
   output logic [7:0]  reg_wr_addr,
   output logic [31:0] reg_wr_data
);
   localparam int unsigned NUM_LINES = 2;

   generate
      if (NUM_REGS < 1 || NUM_REGS > 256) begin : g_bad_regs
         initial $fatal(1, "NUM_REGS must lie in 1..256");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         initial $fatal(1, "SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1 || FILT_LEN > 16) begin : g_bad_filt
         initial $fatal(1, "FILT_LEN must lie in 1..16");
      end
   endgenerate

   logic [NUM_LINES-1:0] line_raw, line_flt;
   assign line_raw = {sda_i, scl_i};

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LINES; gi++) begin : g_line
         i2cvw_deglitch #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
         ) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (line_raw[gi]),
            .dout  (line_flt[gi])
         );
      end
   endgenerate

   logic ev_start, ev_stop, ev_rise, ev_fall;

   i2cvw_busev u_ev (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_f    (line_flt[0]),
      .sda_f    (line_flt[1]),
      .ev_start (ev_start),
      .ev_stop  (ev_stop),
      .ev_rise  (ev_rise),
      .ev_fall  (ev_fall)
   );

   i2cvw_engine #(
      .DEV_ADDR (DEV_ADDR),
      .NUM_REGS (NUM_REGS)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_start (ev_start),
      .ev_stop  (ev_stop),
      .ev_rise  (ev_rise),
      .ev_fall  (ev_fall),
      .sda_f    (line_flt[1]),
      .sda_oe   (sda_oe),
      .rd_addr  (reg_rd_addr),
      .rd_data  (reg_rd_data),
      .wr_en    (reg_wr_en),
      .wr_addr  (reg_wr_addr),
      .wr_data  (reg_wr_data)
   );
endmodule

// File: rtl/i2cvw_slave_chk.sv
`timescale 1ns/1ps
module i2cvw_slave_chk #(
   parameter int unsigned NUM_REGS = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic        scl_i,
   input logic        sda_oe,
   input logic        reg_wr_en,
   input logic [7:0]  reg_wr_addr,
   input logic [31:0] reg_wr_data
);
   logic [5:0]  used_bits;
   logic [31:0] spill;
   assign used_bits = {1'b0, reg_wr_addr[1:0], 3'b000} + 6'd8;
   assign spill     = reg_wr_data >> used_bits;

   // R1: outputs quiet in the first cycle after reset
   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!sda_oe && !reg_wr_en));

   // R3: committed data has no bits above the register width
   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> (spill == 32'd0));

   // R3: a commit strobe lasts one cycle
   a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en);

   // R8: no commit to a subaddress outside the map
   a_r8_no_undef_write: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> ({24'd0, reg_wr_addr} < NUM_REGS));

   // R7: SDA driver changes only while SCL is low
   a_r7_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_i);
endmodule

bind i2cvw_slave i2cvw_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_i       (scl_i),
   .sda_oe      (sda_oe),
   .reg_wr_en   (reg_wr_en),
   .reg_wr_addr (reg_wr_addr),
   .reg_wr_data (reg_wr_data)
);

// File: tb/i2cvw_slave_test.sv
`timescale 1ns/1ps
module i2cvw_slave_test;
   localparam logic [6:0] DEV = 7'h2A;
   localparam int NREG = 16;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1, glitch = 1'b0;
   logic sda_oe, reg_wr_en;
   logic [7:0]  reg_rd_addr, reg_wr_addr;
   logic [31:0] reg_rd_data, reg_wr_data;
   wire scl_line = m_scl & ~glitch;
   wire sda_line = m_sda & ~sda_oe;

   always #2.5 clk = ~clk;

   i2cvw_slave #(.DEV_ADDR(DEV), .NUM_REGS(NREG)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line), .sda_oe(sda_oe),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data));

   logic [31:0] mem [0:NREG-1];
   logic [31:0] exp_mem [0:NREG-1];
   logic        pre_en = 1'b0;
   logic [3:0]  pre_addr = '0;
   logic [31:0] pre_data = '0;
   int wr_count = 0, bad_wr = 0;
   int checks = 0, fails = 0;
   logic [7:0] dbuf [0:15];

   assign reg_rd_data = (reg_rd_addr < 8'd16) ? mem[reg_rd_addr[3:0]] : 32'hA5C3_5A3C;

   always @(posedge clk) begin
      if (pre_en) mem[pre_addr] <= pre_data;
      else if (reg_wr_en && reg_wr_addr < 8'd16) mem[reg_wr_addr[3:0]] <= reg_wr_data;
      if (reg_wr_en) begin
         wr_count <= wr_count + 1;
         if (reg_wr_addr >= 8'd16) bad_wr <= bad_wr + 1;
      end
   end

   function automatic int f_len(input logic [7:0] a);
      return (a < 8'd16) ? int'(a[1:0]) + 1 : 1;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
   endtask

   task automatic i2c_stop();
      m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
   endtask

   task automatic send_byte(input logic [7:0] b, input bit glitch_it, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; qw(); m_scl = 1'b1;
         if (glitch_it && i == 4) begin
            repeat (4) @(negedge clk); glitch = 1'b1;
            repeat (2) @(negedge clk); glitch = 1'b0;
            repeat (Q - 6) @(negedge clk); qw();
         end else begin
            qw(); qw();
         end
         m_scl = 1'b0; qw();
      end
      m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
      ack = !sda_line;
      qw(); m_scl = 1'b0; qw();
   endtask

   task automatic recv_byte(input bit ack_it, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         qw(); m_scl = 1'b1; qw(); b[i] = sda_line; qw(); m_scl = 1'b0;
      end
      m_sda = !ack_it; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
      m_sda = 1'b1;
   endtask

   task automatic preload();
      for (int a = 0; a < NREG; a++) begin
         @(negedge clk);
         pre_en = 1'b1; pre_addr = a[3:0]; pre_data = $urandom;
         exp_mem[a] = pre_data;
      end
      @(negedge clk); pre_en = 1'b0;
   endtask

   task automatic cmp_mem(input string tag);
      int bad = -1;
      for (int a = 0; a < NREG; a++) if (bad < 0 && mem[a] !== exp_mem[a]) bad = a;
      if (bad < 0) chk(1'b1, tag, 32'd0, 32'd0);
      else chk(1'b0, tag, mem[bad], exp_mem[bad]);
   endtask

   // write transaction: subaddress then n bytes from dbuf, model updated per R3/R4/R5/R8
   task automatic wr_txn(input logic [7:0] sub, input int n, input bit gl, input string tag);
      bit ack;
      logic [7:0] p = sub;
      int i = 0;
      logic [31:0] acc = 0;
      i2c_start();
      send_byte({DEV, 1'b0}, 1'b0, ack);
      chk(ack, {tag, " R2 address ack"}, {31'd0, ack}, 32'd1);
      send_byte(sub, 1'b0, ack);
      for (int k = 0; k < n; k++) begin
         send_byte(dbuf[k], gl && k == 0, ack);
         chk(ack, {tag, " R8/R3 data ack"}, {31'd0, ack}, 32'd1);
         acc = (acc << 8) | {24'd0, dbuf[k]};
         i++;
         if (i == f_len(p)) begin
            if (p < 8'd16) exp_mem[p[3:0]] = acc;
            p++; i = 0; acc = 0;
         end
      end
      i2c_stop();
      repeat (4) @(negedge clk);
      cmp_mem(tag);
   endtask

   task automatic rd_txn(input logic [7:0] sub, input int n, input string tag);
      bit ack;
      logic [7:0] p = sub, got, expb;
      int i = 0;
      logic [31:0] wide;
      i2c_start();
      send_byte({DEV, 1'b0}, 1'b0, ack);
      send_byte(sub, 1'b0, ack);
      i2c_start();
      send_byte({DEV, 1'b1}, 1'b0, ack);
      chk(ack, {tag, " R6 read address ack"}, {31'd0, ack}, 32'd1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n - 1, got);
         wide = (p < 8'd16) ? (exp_mem[p[3:0]] >> (8 * (f_len(p) - 1 - i))) : 32'd0;
         expb = wide[7:0];
         chk(got === expb, {tag, " R6/R8 read byte"}, {24'd0, got}, {24'd0, expb});
         i++;
         if (i == f_len(p)) begin p++; i = 0; end
      end
      qw();
      chk(!sda_oe, {tag, " R7 released after nack"}, {31'd0, sda_oe}, 32'd0);
      qw();
      chk(!sda_oe, {tag, " R7 still released"}, {31'd0, sda_oe}, 32'd0);
      i2c_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      bit ack;
      int wc0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(!sda_oe && !reg_wr_en, "R1 reset outputs", {30'd0, sda_oe, reg_wr_en}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!sda_oe && !reg_wr_en, "R1 after reset", {30'd0, sda_oe, reg_wr_en}, 32'd0);
      preload();

      // R3: four-byte register 3 and one-byte register 0
      dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33; dbuf[3] = 8'h44;
      wr_txn(8'd3, 4, 1'b0, "R3 wide write");
      dbuf[0] = 8'h9C;
      wr_txn(8'd0, 1, 1'b0, "R3 narrow write");
      chk(mem[0] === 32'h0000_009C, "R3 upper bits zero", mem[0], 32'h0000_009C);

      // R4: partial write of four-byte register 7
      wc0 = wr_count;
      dbuf[0] = 8'hDE; dbuf[1] = 8'hAD;
      wr_txn(8'd7, 2, 1'b0, "R4 partial write");
      chk(wr_count == wc0, "R4 no strobe", wr_count, wc0);

      // R5: stream over registers 1 (two bytes) and 2 (three bytes)
      for (int k = 0; k < 5; k++) dbuf[k] = 8'h50 + k[7:0];
      wr_txn(8'd1, 5, 1'b0, "R5 stream write");

      // R6/R7: streaming read across registers 1, 2, 3
      rd_txn(8'd1, 8, "R6 stream read");

      // R2: wrong device address
      wc0 = wr_count;
      i2c_start();
      send_byte({DEV ^ 7'h01, 1'b0}, 1'b0, ack);
      chk(!ack, "R2 foreign address nack", {31'd0, ack}, 32'd0);
      send_byte(8'd0, 1'b0, ack);
      chk(!ack, "R2 ignored subaddress", {31'd0, ack}, 32'd0);
      send_byte(8'h77, 1'b0, ack);
      chk(!ack, "R2 ignored data", {31'd0, ack}, 32'd0);
      i2c_stop();
      repeat (4) @(negedge clk);
      chk(wr_count == wc0, "R2 no write", wr_count, wc0);
      cmp_mem("R2 memory unchanged");

      // R8: write runs from register 15 into undefined 16, 17; read over the edge
      for (int k = 0; k < 6; k++) dbuf[k] = 8'hC0 + k[7:0];
      wr_txn(8'd15, 6, 1'b0, "R8 edge write");
      chk(bad_wr == 0, "R8 no undefined strobe", bad_wr, 0);
      rd_txn(8'd14, 9, "R8 edge read");

      // R9: SCL glitch inside a data byte
      dbuf[0] = 8'h3C; dbuf[1] = 8'hA5;
      wr_txn(8'd5, 2, 1'b1, "R9 glitch write");

      // random mix
      for (int t = 0; t < 12; t++) begin
         logic [7:0] sa;
         int nn;
         sa = 8'($urandom_range(0, 19));
         nn = $urandom_range(1, 6);
         for (int k = 0; k < nn; k++) dbuf[k] = 8'($urandom);
         wr_txn(sa, nn, 1'b0, "R5 random write");
         sa = 8'($urandom_range(0, 19));
         rd_txn(sa, $urandom_range(1, 6), "R6 random read");
      end
      chk(bad_wr == 0, "R8 final undefined strobes", bad_wr, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule